// File: doc/BRIEF.md
# Mode-Selectable Byte Port with AXI4-Lite Register Bank

This block is a small memory-mapped peripheral. A processor reaches it through an AXI4-Lite slave port with 32-bit data, and through that port it reads and writes a bank of four 32-bit registers. Alongside the bus, the block has an 8-bit input pin group, an 8-bit output pin group and a level interrupt line.

Register 0 is the control word. Its full 32-bit value decides what drives the output pins:
- a copy of the input pins,
- the inverse of the input pins,
- one of two fixed alternating patterns.

Any control value that names none of these modes falls back to the plain copy. Register 1 is a mixed register: a read returns its stored upper bits, and the live input byte takes the place of its low byte. Registers 2 and 3 are plain scratch storage. The interrupt line mirrors input bit 0 as a level, for an external interrupt controller.

The output pins are a combinational function of the control register and the input pins. A change on either shows on the pins with no added clock delay.

Top module: `axil_gpio_mode`

## Requirements
- R1: A synchronous active-low reset clears all four registers to zero, so the output copies the input. After reset, BVALID and RVALID are low and AWREADY, WREADY and ARREADY are high.
- R2: When register 0 holds 0x00000000, the output pins equal the input pins.
- R3: When register 0 holds 0x00000001, the output pins are the bitwise inverse of the input pins.
- R4: When register 0 holds 0x00000002, the output is 8'b10101010 (the odd-numbered bits set). When it holds 0x00000003, the output is 8'b01010101 (the even-numbered bits set). In both cases the input has no effect on the output.
- R5: Every other 32-bit value in register 0, including values whose low bits match a mode but whose upper bits are nonzero, makes the output copy the input.
- R6: The output pins react to an input change within the same cycle. They react to a control write in the same clock cycle in which BVALID first rises.
- R7: A read of register 1 returns stored bits 31:8 in bits 31:8 and the current input pins in bits 7:0. The input byte is captured at the read-address handshake. RDATA and RVALID hold until RREADY is seen.
- R8: Registers 0, 2 and 3 read back the value last written to them. The register is picked by address bits 3:2, and all other address bits are ignored.
- R9: During a write, bit n of WSTRB enables byte n (bits 8n+7:8n) of the target register. Bytes with a clear strobe bit keep their old value.
- R10: The write address and the write data may arrive in either order. The register changes, and BVALID rises, only after both have been accepted. BVALID stays high until BREADY is seen, and AWREADY and WREADY stay low while BVALID is high.
- R11: BRESP and RRESP are always OKAY (2'b00).
- R12: The interrupt output equals input bit 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_axi_awaddr | input | 12 | Write address |
| s_axi_awvalid | input | 1 | Write address valid |
| s_axi_awready | output | 1 | Write address ready |
| s_axi_wdata | input | 32 | Write data |
| s_axi_wstrb | input | 4 | Write byte strobes |
| s_axi_wvalid | input | 1 | Write data valid |
| s_axi_wready | output | 1 | Write data ready |
| s_axi_bresp | output | 2 | Write response, always OKAY |
| s_axi_bvalid | output | 1 | Write response valid |
| s_axi_bready | input | 1 | Write response ready |
| s_axi_araddr | input | 12 | Read address |
| s_axi_arvalid | input | 1 | Read address valid |
| s_axi_arready | output | 1 | Read address ready |
| s_axi_rdata | output | 32 | Read data |
| s_axi_rresp | output | 2 | Read response, always OKAY |
| s_axi_rvalid | output | 1 | Read data valid |
| s_axi_rready | input | 1 | Read data ready |
| pin_in | input | 8 | Input pin group |
| pin_out | output | 8 | Output pin group, driven according to the register 0 mode |
| irq_out | output | 1 | Level interrupt that follows input bit 0 |

## Verification
The hardest case to reach from the ports is a write split across time. The address is accepted while the data is still missing, or the reverse, and in that gap neither the register nor BVALID may move. The bench drives one channel alone and idles for several cycles, checking BVALID and the output pins. It then supplies the other channel and reads the register back. To catch the same-cycle reaction of the output pins, the bench compares them in the first cycle that BVALID is high, with BREADY held low.

// File: rtl/axil_gpio_mode_pkg.sv
// Package: shared constants and the output-mode type for the mode-selectable
// byte port. Assumes the register word width is 32 bits and responses are OKAY.
package axil_gpio_mode_pkg;

    // Decoded drive mode of the output pins
    typedef enum logic [1:0] {
        OM_COPY     = 2'd0,
        OM_INVERT   = 2'd1,
        OM_PAT_ODD  = 2'd2,
        OM_PAT_EVEN = 2'd3
    } out_mode_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Control words that select a non-default mode
    localparam logic [31:0] CTRL_INVERT   = 32'h0000_0001;
    localparam logic [31:0] CTRL_PAT_ODD  = 32'h0000_0002;
    localparam logic [31:0] CTRL_PAT_EVEN = 32'h0000_0003;

endpackage

// File: rtl/gm_wr_ctrl.sv
// gm_wr_ctrl: AXI4-Lite write-channel handler. It accepts AW and W
// independently, holds each until the other has arrived, then issues a
// one-cycle register write and raises BVALID in that same cycle.
// Assumes: a single outstanding write. AW and W are refused while a response
// is pending.
module gm_wr_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb
);

    logic aw_held;
    logic w_held;
    logic bvalid_q;
    logic unused_aw_bits;

    assign unused_aw_bits = ^{awaddr[ADDR_W-1:IDX_W+2], awaddr[1:0]};

    assign awready = !aw_held && !bvalid_q;
    assign wready  = !w_held && !bvalid_q;
    assign wr_en   = aw_held && w_held;
    assign bvalid  = bvalid_q;

    // Capture address and data, commit the write once both are held, track the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_held  <= 1'b0;
            w_held   <= 1'b0;
            bvalid_q <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            wr_strb  <= '0;
        end else begin
            if (wr_en) begin
                aw_held  <= 1'b0;
                w_held   <= 1'b0;
                bvalid_q <= 1'b1;
            end else begin
                if (awvalid && awready) begin
                    aw_held <= 1'b1;
                    wr_idx  <= awaddr[IDX_W+1:2];
                end
                if (wvalid && wready) begin
                    w_held  <= 1'b1;
                    wr_data <= wdata;
                    wr_strb <= wstrb;
                end
                if (bvalid_q && bready) begin
                    bvalid_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/gm_regbank.sv
// gm_regbank: bank of NUM_REGS words with per-byte write enables.
// Assumes: at most one write per cycle, presented by gm_wr_ctrl. Reset
// clears every word.
module gm_regbank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int STRB_W  = DATA_W / 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [STRB_W-1:0]                 wr_strb,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic              hit;

        assign hit     = wr_en && (wr_idx == IDX_W'(r));
        assign regs[r] = word_q;

        // Store the strobed bytes of a write aimed at this word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit) begin
                for (int b = 0; b < STRB_W; b++) begin
                    if (wr_strb[b]) begin
                        word_q[b*8 +: 8] <= wr_data[b*8 +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gm_rd_ctrl.sv
// gm_rd_ctrl: AXI4-Lite read-channel handler with a registered read mux.
// The word at LIVE_IDX returns its stored upper bits with the live input
// pins in its low bits. The other words return their stored value.
// Assumes: a single outstanding read. The input pins are sampled at the AR
// handshake.
module gm_rd_ctrl #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    parameter int PIN_W    = 8,
    parameter int LIVE_IDX = 1,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               araddr,
    input  logic                            arvalid,
    output logic                            arready,
    output logic [DATA_W-1:0]               rdata,
    output logic                            rvalid,
    input  logic                            rready,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [PIN_W-1:0]                pin_in
);

    logic [IDX_W-1:0]  sel;
    logic [DATA_W-1:0] mux_word;
    logic              rvalid_q;
    logic              unused_ar_bits;

    assign unused_ar_bits = ^{araddr[ADDR_W-1:IDX_W+2], araddr[1:0]};
    assign sel     = araddr[IDX_W+1:2];
    assign arready = !rvalid_q;
    assign rvalid  = rvalid_q;

    // Pick the word to return, splicing in the live pins for the mixed register
    always_comb begin
        if (sel == IDX_W'(LIVE_IDX)) begin
            mux_word = {regs[sel][DATA_W-1:PIN_W], pin_in};
        end else begin
            mux_word = regs[sel];
        end
    end

    // Launch read data on the address handshake and hold it until it is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata    <= '0;
        end else if (arvalid && arready) begin
            rvalid_q <= 1'b1;
            rdata    <= mux_word;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/gm_out_drive.sv
// gm_out_drive: combinational output-pin driver. It decodes the full control
// word into a mode and forms the pins from the input or a fixed pattern.
// Assumes: every undefined control value means copy. No clocked state.
module gm_out_drive #(
    parameter int DATA_W = 32,
    parameter int PIN_W  = 8
) (
    input  logic [DATA_W-1:0] ctrl,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out
);
    import axil_gpio_mode_pkg::*;

    logic [PIN_W-1:0] pat_odd;
    logic [PIN_W-1:0] pat_even;
    out_mode_e        mode;

    for (genvar i = 0; i < PIN_W; i++) begin : g_pat
        assign pat_odd[i]  = (i % 2) == 1;
        assign pat_even[i] = (i % 2) == 0;
    end

    // Decode the full control word into a drive mode
    always_comb begin
        if (ctrl == DATA_W'(CTRL_INVERT)) begin
            mode = OM_INVERT;
        end else if (ctrl == DATA_W'(CTRL_PAT_ODD)) begin
            mode = OM_PAT_ODD;
        end else if (ctrl == DATA_W'(CTRL_PAT_EVEN)) begin
            mode = OM_PAT_EVEN;
        end else begin
            mode = OM_COPY;
        end
    end

    // Form the output pins for the decoded mode
    always_comb begin
        unique case (mode)
            OM_INVERT:   pin_out = ~pin_in;
            OM_PAT_ODD:  pin_out = pat_odd;
            OM_PAT_EVEN: pin_out = pat_even;
            default:     pin_out = pin_in;
        endcase
    end

endmodule

// File: rtl/axil_gpio_mode.sv
// axil_gpio_mode: AXI4-Lite peripheral with four 32-bit registers, an input
// and output pin group and a level interrupt. Register 0 picks the output
// drive mode, register 1 reads back the live input in its low byte, and the
// interrupt mirrors input bit 0.
// Assumes: one outstanding transaction per direction and a synchronous
// active-low reset.
module axil_gpio_mode #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    parameter int PIN_W    = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int STRB_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_axi_awaddr,
    input  logic              s_axi_awvalid,
    output logic              s_axi_awready,
    input  logic [DATA_W-1:0] s_axi_wdata,
    input  logic [STRB_W-1:0] s_axi_wstrb,
    input  logic              s_axi_wvalid,
    output logic              s_axi_wready,
    output logic [1:0]        s_axi_bresp,
    output logic              s_axi_bvalid,
    input  logic              s_axi_bready,
    input  logic [ADDR_W-1:0] s_axi_araddr,
    input  logic              s_axi_arvalid,
    output logic              s_axi_arready,
    output logic [DATA_W-1:0] s_axi_rdata,
    output logic [1:0]        s_axi_rresp,
    output logic              s_axi_rvalid,
    input  logic              s_axi_rready,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic              irq_out
);
    import axil_gpio_mode_pkg::*;

    logic                            wr_en;
    logic [IDX_W-1:0]                wr_idx;
    logic [DATA_W-1:0]               wr_data;
    logic [STRB_W-1:0]               wr_strb;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]               ctrl_word;

    assign ctrl_word   = regs[0];
    assign s_axi_bresp = RESP_OKAY;
    assign s_axi_rresp = RESP_OKAY;
    assign irq_out     = pin_in[0];

    gm_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_axi_awaddr),
        .awvalid (s_axi_awvalid),
        .awready (s_axi_awready),
        .wdata   (s_axi_wdata),
        .wstrb   (s_axi_wstrb),
        .wvalid  (s_axi_wvalid),
        .wready  (s_axi_wready),
        .bvalid  (s_axi_bvalid),
        .bready  (s_axi_bready),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_strb (wr_strb)
    );

    gm_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .regs    (regs)
    );

    gm_rd_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
        .PIN_W(PIN_W), .LIVE_IDX(1)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .araddr  (s_axi_araddr),
        .arvalid (s_axi_arvalid),
        .arready (s_axi_arready),
        .rdata   (s_axi_rdata),
        .rvalid  (s_axi_rvalid),
        .rready  (s_axi_rready),
        .regs    (regs),
        .pin_in  (pin_in)
    );

    gm_out_drive #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_out (
        .ctrl    (ctrl_word),
        .pin_in  (pin_in),
        .pin_out (pin_out)
    );

endmodule

// File: rtl/axil_gpio_mode_chk.sv
// axil_gpio_mode_chk: protocol and mode checks bound to axil_gpio_mode.
// Assumes: it sees the top-level ports plus the stored control word.
module axil_gpio_mode_chk #(
    parameter int DATA_W = 32,
    parameter int PIN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awready,
    input logic              wready,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [1:0]        rresp,
    input logic [DATA_W-1:0] rdata,
    input logic [PIN_W-1:0]  pin_in,
    input logic [PIN_W-1:0]  pin_out,
    input logic [DATA_W-1:0] ctrl
);

    function automatic logic [PIN_W-1:0] alt_bits(input bit odd);
        logic [PIN_W-1:0] v;
        for (int i = 0; i < PIN_W; i++) v[i] = odd ? (i % 2 == 1) : (i % 2 == 0);
        return v;
    endfunction

    // R10: a pending write response is held until accepted
    p_bvalid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);

    // R10: no new write is accepted while a response is pending
    p_no_accept_in_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready && !wready);

    // R7: read data and valid hold until taken
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));

    // R11: responses are always OKAY
    p_okay_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid |-> bresp == 2'b00) and (rvalid |-> rresp == 2'b00));

    // R4: pattern modes ignore the input
    p_pattern_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl == DATA_W'(2)) |-> pin_out == alt_bits(1'b1)) and
        ((ctrl == DATA_W'(3)) |-> pin_out == alt_bits(1'b0)));

    // R5: undefined control values copy the input
    p_fallback_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl > DATA_W'(3)) |-> pin_out == pin_in);

endmodule

bind axil_gpio_mode axil_gpio_mode_chk #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .awready (s_axi_awready),
    .wready  (s_axi_wready),
    .bvalid  (s_axi_bvalid),
    .bready  (s_axi_bready),
    .bresp   (s_axi_bresp),
    .rvalid  (s_axi_rvalid),
    .rready  (s_axi_rready),
    .rresp   (s_axi_rresp),
    .rdata   (s_axi_rdata),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .ctrl    (ctrl_word)
);

// File: tb/axil_gpio_mode_tb.sv
`timescale 1ns/1ps
module axil_gpio_mode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [11:0] araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    axil_gpio_mode u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_axi_awaddr(awaddr), .s_axi_awvalid(awvalid), .s_axi_awready(awready),
        .s_axi_wdata(wdata), .s_axi_wstrb(wstrb), .s_axi_wvalid(wvalid), .s_axi_wready(wready),
        .s_axi_bresp(bresp), .s_axi_bvalid(bvalid), .s_axi_bready(bready),
        .s_axi_araddr(araddr), .s_axi_arvalid(arvalid), .s_axi_arready(arready),
        .s_axi_rdata(rdata), .s_axi_rresp(rresp), .s_axi_rvalid(rvalid), .s_axi_rready(rready),
        .pin_in(pin_in), .pin_out(pin_out), .irq_out(irq_out)
    );

    // Mode table: {control word, input pins, expected output pins}
    localparam int NVEC = 12;
    localparam logic [47:0] VEC [NVEC] = '{
        {32'h0000_0000, 8'h3C, 8'h3C},
        {32'h0000_0000, 8'hA5, 8'hA5},
        {32'h0000_0001, 8'h3C, 8'hC3},
        {32'h0000_0001, 8'h00, 8'hFF},
        {32'h0000_0002, 8'h12, 8'hAA},
        {32'h0000_0002, 8'hFF, 8'hAA},
        {32'h0000_0003, 8'h12, 8'h55},
        {32'h0000_0003, 8'h00, 8'h55},
        {32'h0000_0004, 8'h81, 8'h81},
        {32'hFFFF_FFFF, 8'h7E, 8'h7E},
        {32'h0000_0102, 8'h5A, 8'h5A},
        {32'h8000_0001, 8'h11, 8'h11}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic aw_phase(input logic [11:0] a);
        awaddr = a; awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
    endtask

    task automatic w_phase(input logic [31:0] d, input logic [3:0] s);
        wdata = d; wstrb = s; wvalid = 1'b1;
        while (!wready) @(negedge clk);
        @(negedge clk);
        wvalid = 1'b0;
    endtask

    task automatic b_phase();
        bready = 1'b1;
        while (!bvalid) @(negedge clk);
        check("R11 bresp", {30'd0, bresp}, 32'd0);
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        awaddr = a; awvalid = 1'b1;
        wdata = d; wstrb = s; wvalid = 1'b1;
        while (!(awready && wready)) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        b_phase();
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0; rready = 1'b1;
        while (!rvalid) @(negedge clk);
        d = rdata;
        check("R11 rresp", {30'd0, rresp}, 32'd0);
        @(negedge clk);
        rready = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 bvalid", {31'd0, bvalid}, 32'd0);
        check("R1 rvalid", {31'd0, rvalid}, 32'd0);
        pin_in = 8'h96;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 readies", {29'd0, awready, wready, arready}, 32'h7);
        check("R1 copy after reset", {24'd0, pin_out}, 32'h96);
        rd(12'h000, v); check("R1 reg0 zero", v, 32'h0);
        rd(12'h008, v); check("R1 reg2 zero", v, 32'h0);

        // R2 R3 R4 R5 R12: mode table
        for (int i = 0; i < NVEC; i++) begin
            wr(12'h000, VEC[i][47:16], 4'hF);
            pin_in = VEC[i][15:8];
            @(negedge clk);
            check("R2/R3/R4/R5 pin_out", {24'd0, pin_out}, {24'd0, VEC[i][7:0]});
            check("R12 irq", {31'd0, irq_out}, {31'd0, VEC[i][8]});
        end

        // R6: input change seen the same cycle, no clock edge in between
        wr(12'h000, 32'h1, 4'hF);
        pin_in = 8'h0F; #1;
        check("R6 input to output", {24'd0, pin_out}, 32'hF0);

        // R6: control write shows in the first cycle BVALID is high
        awaddr = 12'h000; awvalid = 1'b1; wdata = 32'h0; wstrb = 4'hF; wvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        check("R6 before write", {24'd0, pin_out}, 32'hF0);
        while (!bvalid) begin
            check("R6 no early change", {24'd0, pin_out}, 32'hF0);
            @(negedge clk);
        end
        check("R6 with bvalid", {24'd0, pin_out}, 32'h0F);
        // R10: response held while BREADY low
        repeat (3) @(negedge clk);
        check("R10 bvalid held", {31'd0, bvalid}, 32'd1);
        check("R10 ready low in b", {30'd0, awready, wready}, 32'd0);
        b_phase();

        // R7: register 1 mixes stored bits and live input
        wr(12'h004, 32'hDEAD_BEEF, 4'hF);
        pin_in = 8'h3A;
        rd(12'h004, v); check("R7 live byte", v, 32'hDEAD_BE3A);
        pin_in = 8'hC5;
        rd(12'h004, v); check("R7 live byte again", v, 32'hDEAD_BEC5);

        // R8: plain read-back and address aliasing
        wr(12'h008, 32'h1234_5678, 4'hF);
        wr(12'h00C, 32'h9ABC_DEF0, 4'hF);
        rd(12'h008, v); check("R8 reg2", v, 32'h1234_5678);
        rd(12'h00C, v); check("R8 reg3", v, 32'h9ABC_DEF0);
        rd(12'hF1B, v); check("R8 alias read reg2", v, 32'h1234_5678);
        wr(12'h7CD, 32'h0BAD_F00D, 4'hF);
        rd(12'h00C, v); check("R8 alias write reg3", v, 32'h0BAD_F00D);

        // R9: byte strobes
        wr(12'h008, 32'hAABB_CCDD, 4'b0101);
        rd(12'h008, v); check("R9 strobe 0101", v, 32'h12BB_56DD);
        wr(12'h008, 32'h0000_0000, 4'b1000);
        rd(12'h008, v); check("R9 strobe 1000", v, 32'h00BB_56DD);
        wr(12'h000, 32'h0000_0002, 4'b0000);
        pin_in = 8'h44; @(negedge clk);
        check("R9 no strobe ignored", {24'd0, pin_out}, 32'h44);

        // R10: address first, data later
        aw_phase(12'h00C);
        repeat (4) @(negedge clk);
        check("R10 aw only no bvalid", {31'd0, bvalid}, 32'd0);
        rd(12'h00C, v); check("R10 aw only unchanged", v, 32'h0BAD_F00D);
        w_phase(32'h1111_2222, 4'hF);
        b_phase();
        rd(12'h00C, v); check("R10 aw then w", v, 32'h1111_2222);

        // R10: data first, address later; control word keeps old mode meanwhile
        pin_in = 8'h3C;
        w_phase(32'h0000_0001, 4'hF);
        repeat (4) @(negedge clk);
        check("R10 w only no bvalid", {31'd0, bvalid}, 32'd0);
        check("R10 w only output", {24'd0, pin_out}, 32'h3C);
        aw_phase(12'h000);
        b_phase();
        check("R10 w then aw output", {24'd0, pin_out}, 32'hC3);

        // R1: reset in the middle clears registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 copy after re-reset", {24'd0, pin_out}, 32'h3C);
        rd(12'h004, v); check("R1 reg1 cleared", v, 32'h0000_003C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule